// File: doc/BRIEF.md
# Gear Ratio Clock Divider Pair

This block sits between a memory controller's core clock and the clock of a high-speed memory channel. It brings the two domains to a common lower frequency so that an external phase detector can line up their rising edges. The controller clock is divided by M. The channel side first derives its sync clock from the bus clock with a fixed divide-by-four, and then divides that sync clock by N. M and N are picked together from a two-bit ratio select, so that the two divided clocks always have the same frequency.

Each domain also raises a transfer strobe. The strobe marks the local cycle whose rising edge is also the rising edge of the divided clock. Those are the cycles in which data may pass straight across the boundary once the external loop has aligned the two domains. The ratio select is captured only while the domain is in reset. Both counters therefore restart at count zero with the new pair, and the divided edges stay aligned.

Top module: `gr_clkdiv_pair`

## Requirements
- R1: The ratio select decodes as 00 → M=1,N=1; 01 → M=4,N=3; 10 → M=3,N=2; 11 → M=2,N=1 (controller-to-sync ratios 1.0, 1.33, 1.5, 2.0).
- R2: For M≥2, the divided controller output repeats every M controller cycles. It is high for the first ceil(M/2) cycles of each period, starting at the edge where the count returns to zero.
- R3: For M=1, once out of reset, the divided controller output is the controller clock itself: high in the high phase and low in the low phase.
- R4: The sync clock output repeats every 4 bus cycles: high for 2 bus cycles, then low for 2.
- R5: The divided sync output repeats every 4N bus cycles and is high for the first 2N of them (exactly 50% duty).
- R6: The controller transfer strobe is high exactly in the controller cycles where the count is zero, which are the cycles in which the divided controller clock rises. With M=1 it is high in every cycle.
- R7: The sync transfer strobe is high for the 4 bus cycles of the sync cycle that starts with the rise of the divided sync output. With N=1 it is high in every cycle.
- R8: While a domain's reset is high, its outputs are low. The first clock edge after reset release starts count zero in both domains, so the sync clock, the divided sync output and the divided controller output all rise and both strobes are high.
- R9: A change of the ratio select while a domain runs has no effect until that domain's next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Controller clock |
| prst_i | input | 1 | Synchronous active-high reset, controller domain |
| busclk_i | input | 1 | Bus clock (4× the sync clock) |
| brst_i | input | 1 | Synchronous active-high reset, bus domain |
| ratio_sel_i | input | 2 | Ratio select, captured during reset (R1 encoding) |
| pclk_div_o | output | 1 | Controller clock divided by M, to phase detector |
| pclk_xfer_o | output | 1 | Controller-domain transfer strobe |
| synclk_o | output | 1 | Sync clock, bus clock divided by 4 |
| sync_div_o | output | 1 | Sync clock divided by N, to phase detector |
| sync_xfer_o | output | 1 | Bus-domain transfer strobe |

## Verification
Every registered output changes on the first clock edge after the state it reflects. The bench indexes cycles from the first edge after reset release, which is index 0 and is already count zero. At each index it predicts every output from M, N and that index, and samples 2 ns after the rising edge. The one combinational path is the M=1 bypass. It is also sampled 2 ns after the falling edge, where the bypass must read low and every registered output must still hold its value. During reset the outputs are sampled the same way and must be low from the first edge. For a select change while running, the index keeps counting against the old pair, and the new pair is checked only after a fresh reset.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int MAX_M = 4;
  localparam int MAX_N = 3;
  localparam int SEL_W = 2;
  localparam int MW    = $clog2(MAX_M + 1);
  localparam int NW    = $clog2(MAX_N + 1);

  // R1: ratio select -> controller divisor
  function automatic logic [MW-1:0] ratio_m(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b01:   ratio_m = MW'(4);
      2'b10:   ratio_m = MW'(3);
      2'b11:   ratio_m = MW'(2);
      default: ratio_m = MW'(1);
    endcase
  endfunction

  // R1: ratio select -> sync divisor
  function automatic logic [NW-1:0] ratio_n(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b01:   ratio_n = NW'(3);
      2'b10:   ratio_n = NW'(2);
      default: ratio_n = NW'(1);
    endcase
  endfunction
endpackage

// File: rtl/gr_ctl_div.sv
module gr_ctl_div #(
  parameter int SEL_W = gr_pkg::SEL_W,
  parameter int MW    = gr_pkg::MW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             div_o,
  output logic             xfer_o
);
  logic [MW-1:0] m_q, cnt_q, cnt_nxt;
  logic          div_q, xfer_q, run_q;

  always_comb cnt_nxt = (cnt_q == m_q - MW'(1)) ? '0 : cnt_q + MW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q    <= gr_pkg::ratio_m(sel);
      cnt_q  <= gr_pkg::ratio_m(sel) - MW'(1);
      div_q  <= 1'b0;
      xfer_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      div_q  <= ({1'b0, cnt_nxt} << 1) < {1'b0, m_q};
      xfer_q <= (cnt_nxt == '0);
      run_q  <= 1'b1;
    end
  end

  assign div_o  = (run_q && m_q == MW'(1)) ? clk : div_q;
  assign xfer_o = xfer_q;

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < m_q);
  assert_rise_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> xfer_q);
  assert_strobe_high_div_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_q |-> div_q);
  assert_ratio_held_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(m_q));
endmodule

// File: rtl/gr_sync_div.sv
module gr_sync_div #(
  parameter int SEL_W = gr_pkg::SEL_W,
  parameter int NW    = gr_pkg::NW,
  localparam int PW   = NW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             synclk_o,
  output logic             div_o,
  output logic             xfer_o
);
  logic [NW-1:0] n_q;
  logic [PW-1:0] pos_q, pos_nxt, per;
  logic          syn_q, div_q, xfer_q;

  always_comb begin
    per     = {n_q, 2'b00};
    pos_nxt = (pos_q == per - PW'(1)) ? '0 : pos_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q    <= gr_pkg::ratio_n(sel);
      pos_q  <= {gr_pkg::ratio_n(sel), 2'b00} - PW'(1);
      syn_q  <= 1'b0;
      div_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt;
      syn_q  <= ~pos_nxt[1];
      div_q  <= pos_nxt < {1'b0, n_q, 1'b0};
      xfer_q <= (pos_nxt[PW-1:2] == '0);
    end
  end

  assign synclk_o = syn_q;
  assign div_o    = div_q;
  assign xfer_o   = xfer_q;

  assert_pos_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    pos_q < per);
  assert_div_rise_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> xfer_q);
  assert_strobe_on_sync_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_q) |-> (syn_q && div_q));
  assert_div_rise_sync_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> syn_q);
  assert_ratio_held_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(n_q));
endmodule

// File: rtl/gr_clkdiv_pair.sv
module gr_clkdiv_pair #(
  parameter int SEL_W = gr_pkg::SEL_W,
  parameter int MW    = gr_pkg::MW,
  parameter int NW    = gr_pkg::NW
) (
  input  logic             pclk_i,
  input  logic             prst_i,
  input  logic             busclk_i,
  input  logic             brst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             pclk_div_o,
  output logic             pclk_xfer_o,
  output logic             synclk_o,
  output logic             sync_div_o,
  output logic             sync_xfer_o
);
  gr_ctl_div #(.SEL_W(SEL_W), .MW(MW)) u_ctl (
    .clk(pclk_i), .rst(prst_i), .sel(ratio_sel_i),
    .div_o(pclk_div_o), .xfer_o(pclk_xfer_o));

  gr_sync_div #(.SEL_W(SEL_W), .NW(NW)) u_sync (
    .clk(busclk_i), .rst(brst_i), .sel(ratio_sel_i),
    .synclk_o(synclk_o), .div_o(sync_div_o), .xfer_o(sync_xfer_o));
endmodule

// File: tb/gr_clkdiv_pair_test.sv
`timescale 1ns/1ps
module gr_clkdiv_pair_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic pdiv, pxfer, synclk, sdiv, sxfer;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  gr_clkdiv_pair uut (
    .pclk_i(clk), .prst_i(rst), .busclk_i(clk), .brst_i(rst),
    .ratio_sel_i(sel), .pclk_div_o(pdiv), .pclk_xfer_o(pxfer),
    .synclk_o(synclk), .sync_div_o(sdiv), .sync_xfer_o(sxfer));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  // R1 encoding, computed independently
  function automatic int m_of(input logic [1:0] s);
    return (s == 2'b01) ? 4 : (s == 2'b10) ? 3 : (s == 2'b11) ? 2 : 1;
  endfunction
  function automatic int n_of(input logic [1:0] s);
    return (s == 2'b01) ? 3 : (s == 2'b10) ? 2 : 1;
  endfunction

  // Hold reset with a select; R8 outputs low during reset; release before next edge
  task automatic do_reset(input logic [1:0] s);
    @(posedge clk); #6; rst = 1'b1; sel = s;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check("R8 reset pdiv", pdiv, 1'b0);
      check("R8 reset pxfer", pxfer, 1'b0);
      check("R8 reset synclk", synclk, 1'b0);
      check("R8 reset sdiv", sdiv, 1'b0);
      check("R8 reset sxfer", sxfer, 1'b0);
    end
    #4; rst = 1'b0;
  endtask

  // Check cycle indices [i0, i0+cnt) against pair (m,n)
  task automatic run_check(input int m, input int n, input int i0, input int cnt);
    for (int i = i0; i < i0 + cnt; i++) begin
      int  c = i % m;
      int  p = i % (4 * n);
      logic ep = (2 * c < m);
      @(posedge clk); #2;
      if (m == 1) check("R3 bypass high phase", pdiv, 1'b1);
      else        check("R2 ctl divided", pdiv, ep);
      check("R6 ctl strobe", pxfer, c == 0);
      check("R4 sync clock", synclk, (p % 4) < 2);
      check("R5 sync divided", sdiv, p < 2 * n);
      check("R7 sync strobe", sxfer, p < 4);
      if (i == 0) check("R8 first edge rise", pdiv & synclk & sdiv, 1'b1);
      #4;
      if (m == 1) check("R3 bypass low phase", pdiv, 1'b0);
      else        check("R2 ctl stable low phase", pdiv, ep);
    end
  endtask

  task automatic t_ratio(input logic [1:0] s);
    do_reset(s);
    run_check(m_of(s), n_of(s), 0, 36);
  endtask

  // R9: select change while running keeps the old pair
  task automatic t_ignore_change();
    do_reset(2'b01);
    run_check(4, 3, 0, 5);
    sel = 2'b10;
    run_check(4, 3, 5, 31);
    sel = 2'b11;
    run_check(4, 3, 36, 12);
  endtask

  initial begin
    t_ratio(2'b00);
    t_ratio(2'b01);
    t_ratio(2'b10);
    t_ratio(2'b11);
    t_ignore_change();
    t_ratio(2'b10); // R9: new pair applies after reset
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule